// File: doc/BRIEF.md
# Programmable Trigger Holdoff Timer

The block stops a trigger path from accepting a new event for a programmable time after each accepted event. When a trigger is accepted, a ramp accumulator starts from zero and climbs by a fixed step on every clock. When the ramp reaches a reference word, the ramp clears at once and the trigger path is armed again. A processor picks the ramp slope through a small select register and reads back two status bits: one says a trigger has been taken, the other says holdoff is in progress.

The slope is built from a permanent base step of 1 unit plus three switchable steps of 4, 16 and 64 units. A range bit then either keeps that sum as it is or divides it by eight, which gives a coarse and a fine range. The ramp runs in eighths of a unit, so the fine range stays exact. The reference is compared in whole units. The same register carries one more bit, which drives an external reset line straight through.

There are two states. ARMED: trigger enable is high and the ramp is held at zero. HOLD: trigger enable is low and the ramp climbs. ARM_TO_HOLD is taken on a clock where a trigger arrives in ARMED. HOLD_TO_ARM is taken on the clock where the ramp plus the step reaches the reference.

Top module: `holdoff_timer`

## Requirements
- R1: After reset, trig_enable is 1, status_o is 0 and ext_reset_o is 0.
- R2: A write (wr_en high) loads wr_data into the select register at the clock edge. Bit layout: bits 2:0 enable the extra steps of 4, 16 and 64 units, bit 3 selects the fine range, and bit 4 drives ext_reset_o from the next cycle on.
- R3: Let total = 1 + 4·b0 + 16·b1 + 64·b2. The ramp advances by 8·total eighths per clock when bit 3 is 0, and by total eighths when bit 3 is 1. For a reference ref > 0, trig_enable stays low for exactly ceil(8·ref / step) cycles.
- R4: A trig_in high on a cycle where trig_enable is high is accepted. On the next cycle trig_enable is 0 and status_o[1] (holdoff active) is 1.
- R5: A trig_in arriving while trig_enable is low is dropped. It does not set status_o[0], and it is not queued: trig_enable stays high after the holdoff ends.
- R6: Holdoff ends on the clock where the ramp reaches the reference, and the ramp restarts from zero. Back-to-back holdoffs with the same settings therefore last the same number of cycles.
- R7: status_o[0] sets on an accepted trigger and stays set until status_rd is pulsed. When an accept and status_rd fall on the same cycle, the set wins.
- R8: A select write during holdoff changes the step from the clock after the write edge on. The ramp keeps its accumulated value.
- R9: With ref_level = 0, holdoff lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Trigger event, sampled each clock |
| wr_en | input | 1 | Select register write strobe |
| wr_data | input | 5 | Select register write data |
| status_rd | input | 1 | Status read strobe; clears the trigger-seen bit |
| ref_level | input | 8 | Holdoff reference level, in whole units |
| trig_enable | output | 1 | High when a trigger can be accepted |
| status_o | output | 2 | bit 0 trigger seen, bit 1 holdoff active |
| ext_reset_o | output | 1 | External reset output, from select bit 4 |

## Verification
An accepted trigger shows on trig_enable and status_o one cycle after its edge. A holdoff of N cycles keeps trig_enable low at the N sampling points after that edge, and trig_enable is high again after the Nth edge. A select write is visible on ext_reset_o one cycle after its edge, but it changes the ramp step only from the edge after that. The bench drives all inputs at falling edges and samples at falling edges. It counts low samples for holdoff lengths, and it places the mid-holdoff write check at the exact edge where a write that took effect too early, or that restarted the ramp, would end holdoff one cycle earlier or later.

// File: rtl/holdoff_pkg.sv
package holdoff_pkg;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_HOLD  = 1'b1
    } hold_state_t;

    localparam int STAT_SEEN = 0;
    localparam int STAT_HOLD = 1;
    localparam int STAT_W    = 2;

endpackage

// File: rtl/holdoff_slope.sv
module holdoff_slope #(
    parameter int SRC_N         = 3,
    parameter int SRC_SHIFT     = 2,
    parameter int BASE_INC      = 1,
    parameter int CAP_DIV_SHIFT = 3,
    parameter int TOT_W         = 7,
    parameter int STEP_W        = 10
) (
    input  logic [SRC_N-1:0]  src_en,
    input  logic              fine_sel,
    output logic [STEP_W-1:0] step
);

    logic [TOT_W-1:0] term [SRC_N];
    logic [TOT_W-1:0] total;

    // one weighted term per switchable source
    generate
        for (genvar i = 0; i < SRC_N; i++) begin : g_src
            assign term[i] = src_en[i] ? (TOT_W'(1) << (SRC_SHIFT * (i + 1))) : '0;
        end
    endgenerate

    always_comb begin
        total = TOT_W'(BASE_INC);
        for (int i = 0; i < SRC_N; i++) begin
            total = total + term[i];
        end
    end

    // ramp counts in eighths: the coarse range scales up, the fine range does not
    assign step = fine_sel ? STEP_W'(total) : (STEP_W'(total) << CAP_DIV_SHIFT);

endmodule

// File: rtl/holdoff_ramp_fsm.sv
module holdoff_ramp_fsm
    import holdoff_pkg::*;
#(
    parameter int REF_W         = 8,
    parameter int STEP_W        = 10,
    parameter int ACC_W         = 12,
    parameter int CAP_DIV_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic [STEP_W-1:0] step,
    input  logic [REF_W-1:0]  ref_level,
    output logic              trig_enable,
    output logic              hold_active,
    output logic              accept,
    output logic [ACC_W-1:0]  ramp_acc
);

    hold_state_t      state_q, state_d;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] ref_scaled;
    logic             crossed;

    assign acc_sum    = ramp_acc + ACC_W'(step);
    assign ref_scaled = ACC_W'({ref_level, {CAP_DIV_SHIFT{1'b0}}});
    assign crossed    = (acc_sum >= ref_scaled);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_ARMED;
            ramp_acc <= '0;
        end else begin
            state_q  <= state_d;
            ramp_acc <= acc_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        acc_d   = '0;
        unique case (state_q)
            ST_ARMED: begin
                if (trig_in) state_d = ST_HOLD;       // ARM_TO_HOLD
            end
            ST_HOLD: begin
                if (crossed) state_d = ST_ARMED;      // HOLD_TO_ARM, ramp cleared
                else         acc_d   = acc_sum;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        trig_enable = 1'b0;
        hold_active = 1'b0;
        accept      = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                trig_enable = 1'b1;
                accept      = trig_in;
            end
            ST_HOLD:  hold_active = 1'b1;
            default:  trig_enable = 1'b0;
        endcase
    end

endmodule

// File: rtl/holdoff_ctrl_regs.sv
module holdoff_ctrl_regs
    import holdoff_pkg::*;
#(
    parameter int SEL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_data,
    input  logic              status_rd,
    input  logic              accept,
    input  logic              hold_active,
    output logic [SEL_W-1:0]  sel_q,
    output logic [STAT_W-1:0] status_o
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (wr_en) sel_q <= wr_data;
            if (accept)         seen_q <= 1'b1;   // set has priority over clear
            else if (status_rd) seen_q <= 1'b0;
        end
    end

    always_comb begin
        status_o            = '0;
        status_o[STAT_SEEN] = seen_q;
        status_o[STAT_HOLD] = hold_active;
    end

endmodule

// File: rtl/holdoff_timer.sv
module holdoff_timer
    import holdoff_pkg::*;
#(
    parameter int SRC_N         = 3,
    parameter int SRC_SHIFT     = 2,
    parameter int BASE_INC      = 1,
    parameter int CAP_DIV_SHIFT = 3,
    parameter int REF_W         = 8,
    localparam int SEL_W        = SRC_N + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_data,
    input  logic              status_rd,
    input  logic [REF_W-1:0]  ref_level,
    output logic              trig_enable,
    output logic [STAT_W-1:0] status_o,
    output logic              ext_reset_o
);

    localparam int TOT_W  = SRC_SHIFT * SRC_N + 1;
    localparam int STEP_W = TOT_W + CAP_DIV_SHIFT;
    localparam int REF_SC = REF_W + CAP_DIV_SHIFT;
    localparam int ACC_W  = ((REF_SC > STEP_W) ? REF_SC : STEP_W) + 1;
    localparam int FINE_B = SRC_N;
    localparam int XRST_B = SRC_N + 1;

    logic [SEL_W-1:0]  sel_q;
    logic [STEP_W-1:0] ramp_step;
    logic [ACC_W-1:0]  ramp_acc;
    logic              hold_active;
    logic              accept;

    holdoff_ctrl_regs #(.SEL_W(SEL_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .status_rd   (status_rd),
        .accept      (accept),
        .hold_active (hold_active),
        .sel_q       (sel_q),
        .status_o    (status_o)
    );

    holdoff_slope #(
        .SRC_N(SRC_N), .SRC_SHIFT(SRC_SHIFT), .BASE_INC(BASE_INC),
        .CAP_DIV_SHIFT(CAP_DIV_SHIFT), .TOT_W(TOT_W), .STEP_W(STEP_W)
    ) u_slope (
        .src_en   (sel_q[SRC_N-1:0]),
        .fine_sel (sel_q[FINE_B]),
        .step     (ramp_step)
    );

    holdoff_ramp_fsm #(
        .REF_W(REF_W), .STEP_W(STEP_W), .ACC_W(ACC_W), .CAP_DIV_SHIFT(CAP_DIV_SHIFT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_in     (trig_in),
        .step        (ramp_step),
        .ref_level   (ref_level),
        .trig_enable (trig_enable),
        .hold_active (hold_active),
        .accept      (accept),
        .ramp_acc    (ramp_acc)
    );

    assign ext_reset_o = sel_q[XRST_B];

endmodule

// File: rtl/holdoff_timer_chk.sv
module holdoff_timer_chk #(
    parameter int SEL_W         = 5,
    parameter int REF_W         = 8,
    parameter int STEP_W        = 10,
    parameter int ACC_W         = 12,
    parameter int CAP_DIV_SHIFT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_in,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_data,
    input logic [REF_W-1:0]  ref_level,
    input logic              trig_enable,
    input logic [1:0]        status_o,
    input logic              ext_reset_o,
    input logic [STEP_W-1:0] ramp_step,
    input logic [ACC_W-1:0]  ramp_acc
);

    logic [ACC_W-1:0] ref_sc;
    logic [ACC_W-1:0] next_sum;
    assign ref_sc   = ACC_W'({ref_level, {CAP_DIV_SHIFT{1'b0}}});
    assign next_sum = ramp_acc + ACC_W'(ramp_step);

    p_ext_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ext_reset_o == $past(wr_data[SEL_W-1])));

    p_ramp_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_enable && (next_sum < ref_sc)) |=>
            (!trig_enable && (ramp_acc == $past(ramp_acc) + ACC_W'($past(ramp_step)))));

    p_accept_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_enable && trig_in) |=> (!trig_enable && status_o[1]));

    p_drop_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_enable && trig_in && !status_o[0]) |=> !status_o[0]);

    p_cross_rearms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_enable && (next_sum >= ref_sc)) |=> trig_enable);

    p_armed_ramp_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_enable |-> (ramp_acc == '0));

    p_seen_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_enable && trig_in) |=> status_o[0]);

    p_zero_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_enable && (ref_level == '0)) |=> trig_enable);

endmodule

bind holdoff_timer holdoff_timer_chk #(
    .SEL_W(SEL_W), .REF_W(REF_W), .STEP_W(STEP_W), .ACC_W(ACC_W),
    .CAP_DIV_SHIFT(CAP_DIV_SHIFT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_in     (trig_in),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .ref_level   (ref_level),
    .trig_enable (trig_enable),
    .status_o    (status_o),
    .ext_reset_o (ext_reset_o),
    .ramp_step   (ramp_step),
    .ramp_acc    (ramp_acc)
);

// File: tb/sim_holdoff_timer.sv
module sim_holdoff_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic       status_rd = 1'b0;
    logic [7:0] ref_level = '0;
    logic       trig_enable;
    logic [1:0] status_o;
    logic       ext_reset_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    holdoff_timer u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .wr_en(wr_en),
        .wr_data(wr_data), .status_rd(status_rd), .ref_level(ref_level),
        .trig_enable(trig_enable), .status_o(status_o), .ext_reset_o(ext_reset_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic int exp_len(input logic [3:0] cfg, input int rv);
        int total = 1 + (cfg[0] ? 4 : 0) + (cfg[1] ? 16 : 0) + (cfg[2] ? 64 : 0);
        int step  = cfg[3] ? total : total * 8;
        if (rv == 0) return 1;
        return (rv * 8 + step - 1) / step;
    endfunction

    task automatic write_sel(input logic [4:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // starts at a falling edge with the path armed; returns cycles spent low
    task automatic run_holdoff(output int n);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        chk(status_o[1] == 1'b1 && trig_enable == 1'b0, "R4 accept enters holdoff",
            int'(status_o[1]), 1);
        n = 0;
        while (!trig_enable && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int n, n2;
        int refs [6] = '{0, 1, 5, 8, 37, 200};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(trig_enable == 1'b1, "R1 reset enable", int'(trig_enable), 1);
        chk(status_o == 2'b00, "R1 reset status", int'(status_o), 0);
        chk(ext_reset_o == 1'b0, "R1 reset ext", int'(ext_reset_o), 0);

        // R3 / R9 sweep over every slope configuration
        for (int c = 0; c < 16; c++) begin
            for (int r = 0; r < 6; r++) begin
                logic [4:0] d;
                d = {c[0] ^ c[1], c[3:0]};
                ref_level = 8'(refs[r]);
                write_sel(d);
                chk(ext_reset_o == d[4], "R2 ext reset follows bit 4", int'(ext_reset_o), int'(d[4]));
                run_holdoff(n);
                chk(n == exp_len(c[3:0], refs[r]),
                    (refs[r] == 0) ? "R9 zero reference length" : "R3 holdoff length",
                    n, exp_len(c[3:0], refs[r]));
            end
        end

        // R6 back-to-back holdoffs restart the ramp
        write_sel(5'b00000);
        ref_level = 8'd13;
        run_holdoff(n);
        run_holdoff(n2);
        chk(n == 13, "R6 first holdoff", n, 13);
        chk(n2 == 13, "R6 second holdoff", n2, 13);

        // R7 clear, then R5 drop during holdoff
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        chk(status_o[0] == 1'b0, "R7 read clears seen", int'(status_o[0]), 0);
        ref_level = 8'd6;
        trig_in = 1'b1; status_rd = 1'b1;           // set wins over clear
        @(negedge clk);
        trig_in = 1'b0; status_rd = 1'b0;
        chk(status_o[0] == 1'b1, "R7 set wins over clear", int'(status_o[0]), 1);
        status_rd = 1'b1; trig_in = 1'b1;           // dropped trigger plus clear
        @(negedge clk);
        status_rd = 1'b0; trig_in = 1'b0;
        chk(status_o[0] == 1'b0, "R5 dropped trigger sets no seen", int'(status_o[0]), 0);
        n = 0;
        while (!trig_enable && n < 100) begin n++; @(negedge clk); end
        for (int k = 0; k < 4; k++) begin
            chk(trig_enable == 1'b1, "R5 dropped trigger not queued", int'(trig_enable), 1);
            @(negedge clk);
        end
        chk(status_o[0] == 1'b0, "R5 seen still clear", int'(status_o[0]), 0);

        // R8 slope change mid holdoff, step 8 then 40, reference 96 eighths
        ref_level = 8'd12;
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 5'b00001;
        @(negedge clk);
        wr_en = 1'b0;
        chk(trig_enable == 1'b0, "R8 holdoff after write", int'(trig_enable), 0);
        @(negedge clk);
        chk(trig_enable == 1'b0, "R8 ramp kept, new step next clock", int'(trig_enable), 0);
        @(negedge clk);
        chk(trig_enable == 1'b1, "R8 holdoff ends on schedule", int'(trig_enable), 1);

        done = 1'b1;
        finish_run();
    end

endmodule